// File: doc/BRIEF.md
# Reset Conditioning Unit

This block turns a noisy external active-low reset pin and a one-bit power-good indication into a clean internal active-low reset for a chip running from a free-running clock, nominally 40 MHz. The external pin first passes through a synchronizer. A run-length filter then ignores low pulses that are too short to be a real reset request. Any low level that survives the filter holds the internal reset asserted for as long as it lasts.

Power-good works as the block's own asynchronous clear. While it is low, the internal reset is asserted at once, without waiting for a clock. When it rises, a stretch counter keeps the reset asserted for a fixed number of cycles: 1320 by default, about 33 µs at 40 MHz. The internal reset is always released on a rising clock edge, and only once the stretch has expired and the filtered pin is high.

Top module: `reset_conditioner`

## Requirements
- R1: While `pwr_good` is 0, `rst_out_n` is 0, including between clock edges: it follows a falling `pwr_good` without waiting for a clock.
- R2: After `pwr_good` rises, `rst_out_n` stays 0 through the first POR_CYCLES rising edges. It becomes 1 at rising edge POR_CYCLES+1, provided the filtered pin is high.
- R3: A low run of `pin_rst_n` spanning fewer than FILT_CYCLES consecutive rising-edge samples never drives `rst_out_n` to 0.
- R4: When `pin_rst_n` is sampled low at FILT_CYCLES consecutive edges, the first of them edge e, `rst_out_n` is 0 after edge e+FILT_CYCLES+SYNC_STAGES.
- R5: After `pin_rst_n` returns high at sampled edge h, with the stretch expired, `rst_out_n` returns to 1 at edge h+SYNC_STAGES+1, exactly on a rising clock edge.
- R6: A low level lasting 40 cycles (1 µs at 40 MHz) always produces an internal reset that lasts as long as the low level.
- R7: A rejected glitch leaves nothing behind. Two sub-threshold low runs separated by a single high sample do not add up to a reset.
- R8: A pin reset during or across the power-on stretch neither shortens the stretch nor prolongs it. Release happens on the later of the two release conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous to `clk` |
| pwr_good | input | 1 | Supply-valid flag; 0 clears the block asynchronously |
| rst_out_n | output | 1 | Conditioned internal reset, active low |

## Verification
The bench targets glitches exactly one sample shorter than the threshold, both alone and back to back with a single high sample between them. A filter that does not clear its count would merge such pairs into a false reset. Runs of exactly the threshold length and 40-cycle holds pin down the assert and release latency, which is where an extra or missing synchronizer or output stage would show up. Pin resets that overlap the stretch, and a power-good drop in mid-cycle, expose a stretch counter that restarts or stops early, and an output that waits for a clock before asserting.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  // Number of bits needed to hold every value 0..n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((64'd1 << b) <= 64'(n)) b++;
    return b;
  endfunction

  // Total edges from the first low pin sample to reset assertion.
  function automatic int unsigned assert_latency(input int unsigned sync_stages,
                                                 input int unsigned filt_cycles);
    return sync_stages + filt_cycles;
  endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '1;
        else         chain <= d_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '1;
        else         chain <= {chain[STAGES-2:0], d_n};
      end
    end
  endgenerate

  assign q_n = chain[STAGES-1];
endmodule

// File: rtl/rstc_glitch_filter.sv
module rstc_glitch_filter
  import rstc_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sync_n,
  output logic qual_low
);
  localparam int unsigned W = cnt_bits(FILT_CYCLES);
  localparam logic [W-1:0] LAST = W'(FILT_CYCLES - 1);

  logic [W-1:0] run_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_cnt  <= '0;
      qual_low <= 1'b0;
    end else if (sync_n) begin
      run_cnt  <= '0;
      qual_low <= 1'b0;
    end else if (run_cnt == LAST) begin
      qual_low <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstc_por_stretch.sv
module rstc_por_stretch
  import rstc_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 1320
) (
  input  logic clk,
  input  logic arst_n,
  output logic por_done
);
  localparam int unsigned W = cnt_bits(POR_CYCLES);
  localparam logic [W-1:0] TOP = W'(POR_CYCLES);

  logic [W-1:0] age;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         age <= '0;
    else if (age != TOP) age <= age + 1'b1;
  end

  assign por_done = (age == TOP);
endmodule

// File: rtl/rstc_release.sv
module rstc_release (
  input  logic clk,
  input  logic arst_n,
  input  logic por_done,
  input  logic qual_low,
  output logic rst_out_n
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_out_n <= 1'b0;
    else         rst_out_n <= por_done & ~qual_low;
  end
endmodule

// File: rtl/reset_conditioner.sv
module reset_conditioner #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYCLES = 2,
  parameter int unsigned POR_CYCLES  = 1320
) (
  input  logic clk,
  input  logic pin_rst_n,
  input  logic pwr_good,
  output logic rst_out_n
);
  logic sync_n;
  logic qual_low;
  logic por_done;

  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (pwr_good),
    .d_n    (pin_rst_n),
    .q_n    (sync_n)
  );

  rstc_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk      (clk),
    .arst_n   (pwr_good),
    .sync_n   (sync_n),
    .qual_low (qual_low)
  );

  rstc_por_stretch #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk      (clk),
    .arst_n   (pwr_good),
    .por_done (por_done)
  );

  rstc_release u_rel (
    .clk       (clk),
    .arst_n    (pwr_good),
    .por_done  (por_done),
    .qual_low  (qual_low),
    .rst_out_n (rst_out_n)
  );
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
  import rstc_pkg::*;
#(
  parameter int unsigned FILT = 2
) (
  input logic clk,
  input logic pwr_good,
  input logic rst_out_n,
  input logic sync_n,
  input logic qual_low,
  input logic por_done
);
  localparam int unsigned W = cnt_bits(FILT);
  localparam logic [W-1:0] SAT = W'(FILT);

  // Count of consecutive low synchronizer samples, kept independently of the filter.
  logic [W-1:0] low_run;
  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)       low_run <= '0;
    else if (sync_n)     low_run <= '0;
    else if (low_run != SAT) low_run <= low_run + 1'b1;
  end

  assert_power_low_R1: assert property (@(posedge clk) !pwr_good |-> !rst_out_n);

  assert_por_hold_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    !por_done |=> !rst_out_n);

  assert_filter_min_R3: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(qual_low) |-> (low_run >= SAT));

  assert_qual_reset_R4: assert property (@(posedge clk) disable iff (!pwr_good)
    qual_low |=> !rst_out_n);

  assert_release_R5: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(rst_out_n) |-> ($past(por_done) && !$past(qual_low)));

  assert_glitch_clear_R7: assert property (@(posedge clk) disable iff (!pwr_good)
    sync_n |=> !qual_low);
endmodule

bind reset_conditioner rstc_checker #(.FILT(FILT_CYCLES)) u_chk (
  .clk       (clk),
  .pwr_good  (pwr_good),
  .rst_out_n (rst_out_n),
  .sync_n    (sync_n),
  .qual_low  (qual_low),
  .por_done  (por_done)
);

// File: tb/tb_reset_conditioner.sv
`timescale 1ns/1ps
module tb_reset_conditioner;
  localparam int SYNC = 2;
  localparam int FILT = 2;
  localparam int POR  = 1320;
  localparam int HW   = 8;

  logic clk = 1'b0;
  logic pin_rst_n = 1'b1;
  logic pwr_good = 1'b0;
  logic rst_out_n;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  reset_conditioner dut (
    .clk       (clk),
    .pin_rst_n (pin_rst_n),
    .pwr_good  (pwr_good),
    .rst_out_n (rst_out_n)
  );

  // Bench view: edges since power-good release and pin history (bit k = k edges back).
  int edges;
  logic [HW-1:0] hist;
  always @(posedge clk) begin
    if (!pwr_good) begin
      edges <= 0;
      hist  <= '1;
    end else begin
      edges <= edges + 1;
      hist  <= {hist[HW-2:0], pin_rst_n};
    end
  end

  // Reset is released when stretch is over and the filter window is not all low.
  function automatic logic expect_out(input logic pg, input int n, input logic [HW-1:0] h);
    logic all_low;
    if (!pg) return 1'b0;
    if (n < POR + 1) return 1'b0;
    all_low = 1'b1;
    for (int k = SYNC + 1; k <= SYNC + FILT; k++)
      if (h[k]) all_low = 1'b0;
    return !all_low;
  endfunction

  task automatic check(input string tag);
    logic e;
    e = expect_out(pwr_good, edges, hist);
    checks++;
    if (rst_out_n !== e) begin
      failures++;
      $display("FAIL %s: rst_out_n actual=%b expected=%b edges=%0d t=%0t",
               tag, rst_out_n, e, edges, $time);
    end
  endtask

  task automatic hold(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  task automatic low_pulse(input string tag, input int len, input int gap);
    pin_rst_n = 1'b0;
    hold(tag, len);
    pin_rst_n = 1'b1;
    hold(tag, gap);
  endtask

  task automatic power_up(input string tag);
    pwr_good = 1'b0;
    hold(tag, 3);
    pwr_good = 1'b1;
    hold(tag, POR + 6);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    // R1: reset state while power-good is low
    hold("R1", 4);
    pwr_good = 1'b1;
    // R2: stretch length and synchronous release
    hold("R2", POR + 8);
    // R3: single glitch one sample short
    low_pulse("R3", FILT - 1, 12);
    low_pulse("R3", 1, 12);
    // R7: two sub-threshold runs split by one high sample
    pin_rst_n = 1'b0; hold("R7", FILT - 1);
    pin_rst_n = 1'b1; hold("R7", 1);
    pin_rst_n = 1'b0; hold("R7", FILT - 1);
    pin_rst_n = 1'b1; hold("R7", 12);
    // R4: run of exactly the threshold length
    low_pulse("R4", FILT, 12);
    low_pulse("R4", FILT + 1, 12);
    // R6 and R5: 1 us hold and release latency
    low_pulse("R6", 40, 3);
    hold("R5", 10);
    // R8: pin held low across the whole stretch, released after it
    pwr_good = 1'b0; pin_rst_n = 1'b0;
    hold("R8", 3);
    pwr_good = 1'b1;
    hold("R8", POR + 40);
    pin_rst_n = 1'b1;
    hold("R8", 10);
    // R8: pin pulse inside the stretch must not move the release
    power_up("R1");
    pwr_good = 1'b0;
    hold("R8", 2);
    pwr_good = 1'b1;
    hold("R8", 100);
    low_pulse("R8", 50, POR);
    // R1: asynchronous assertion in mid-cycle
    @(negedge clk);
    pwr_good = 1'b0;
    #1;
    checks++;
    if (rst_out_n !== 1'b0) begin
      failures++;
      $display("FAIL R1: async rst_out_n actual=%b expected=0", rst_out_n);
    end
    hold("R1", 3);
    pwr_good = 1'b1;
    hold("R2", POR + 4);
    // Random mix covering R3, R4, R5, R7
    for (int i = 0; i < 300; i++) begin
      int len;
      int gap;
      len = ($urandom_range(0, 9) == 0) ? 40 : int'($urandom_range(1, 6));
      gap = int'($urandom_range(1, 25));
      low_pulse((len < FILT) ? "R3_rand" : "R4_R5_rand", len, gap);
      if (i == 150) power_up("R2_rand");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule